// File: doc/BRIEF.md
# Single-Clock Queue with Last-Entry Overwrite

This block is a first-in first-out queue that runs on one clock. It stores `WIDTH`-bit words in a ring of `DEPTH` slots, and `DEPTH` need not be a power of two. It reports how many words it holds, whether a read can be taken and whether a write can be accepted.

A producer normally appends words. It can also raise `replace` together with `wr_en` to overwrite the newest word already queued, which leaves the count unchanged. This suits a producer that refines its latest result before the consumer takes it.

The parameter `FWFT` selects how read data is presented. With `FWFT=1` the oldest word is visible on `dout` whenever the queue is non-empty, and a read retires that word. With `FWFT=0`, `dout` is a register that loads the oldest word on the clock edge that accepts a read.

Top module: `fifo_rp`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `level` is 0, `readable` is 0 and `writable` is 1. With `FWFT=0`, `dout` is 0.
- R2: At each clock edge `level` rises by one for an append (`wr_en`=1, `replace`=0, `writable`=1) and falls by one for an accepted read (`rd_en`=1, `readable`=1). When both happen in the same cycle, `level` is unchanged.
- R3: `readable` is 1 exactly when `level` is non-zero. `writable` is 1 exactly when `level` is below `DEPTH`.
- R4: If `rd_en` was 0 in the previous cycle, `dout` keeps its previous value. The only exception is the one given in R5.
- R5: With `FWFT=1`, if `rd_en` was 0 in the previous cycle, `wr_en` was 1, and either `writable` or `replace` was 1, and `level` is now 1, then `dout` equals the previous cycle's `din`.
- R6: Words leave in the order they were appended. With `FWFT=1`, `dout` shows the oldest word while `readable` is 1. With `FWFT=0`, `dout` takes the oldest word in the cycle after an accepted read.
- R7: `wr_en`=1 with `replace`=1 while the queue is non-empty overwrites the most recently appended word and leaves `level` unchanged. This also works when the queue is full. With the queue empty it has no effect.
- R8: An append while `writable` is 0 is dropped, even when a read is accepted in the same cycle. That read still retires its word.
- R9: A read while `readable` is 0 has no effect. `level` stays 0 and a registered `dout` keeps its value.
- R10: The slot pointers wrap from `DEPTH-1` back to 0, so ordering holds across many more than `DEPTH` words at a non-power-of-two depth.
- R11: When a read and an overwrite hit the single queued word in the same cycle, the read returns the word as it was before the overwrite.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| replace | input | 1 | With `wr_en`, overwrite the newest word instead of appending |
| din | input | WIDTH | Write data |
| writable | output | 1 | Queue has a free slot |
| rd_en | input | 1 | Read request |
| dout | output | WIDTH | Read data |
| readable | output | 1 | Queue holds at least one word |
| level | output | $clog2(DEPTH+1) | Number of words held |

## Verification
The critical overlap is a read and a write landing in the same cycle. This includes a read against an overwrite of the very word being retired, and a read against an append that is dropped because the queue is full. The bench drives these pairs on purpose at levels 1 and `DEPTH`, and also produces them often with a pseudo-random mix. A behavioural queue model resolves each cycle in a fixed order: capture the head, overwrite the tail, retire the head, then append. Both output modes are compared against that model on every clock.

// File: rtl/fifo_rp_pkg.sv
package fifo_rp_pkg;

    // Storage write operation for one cycle.
    typedef enum logic [1:0] {
        WK_IDLE      = 2'd0,
        WK_APPEND    = 2'd1,
        WK_OVERWRITE = 2'd2
    } wr_kind_e;

    // Accepted operations for one cycle.
    typedef struct packed {
        logic push;
        logic over;
        logic pop;
    } acc_t;

    // Ring step forward with an explicit wrap at n-1.
    function automatic int step_fwd(input int p, input int n);
        return (p == n - 1) ? 0 : p + 1;
    endfunction

    // Ring step backward with an explicit wrap to n-1.
    function automatic int step_back(input int p, input int n);
        return (p == 0) ? n - 1 : p - 1;
    endfunction

endpackage

// File: rtl/fifo_rp_ctrl.sv
module fifo_rp_ctrl
    import fifo_rp_pkg::*;
#(
    parameter int DEPTH = 5,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             replace,
    input  logic             rd_en,
    output wr_kind_e         kind,
    output logic [PTR_W-1:0] wr_addr,
    output logic [PTR_W-1:0] rd_addr,
    output logic             pop,
    output logic [LVL_W-1:0] level,
    output logic             readable,
    output logic             writable
);

    logic [PTR_W-1:0] wr_ptr_q;
    logic [PTR_W-1:0] rd_ptr_q;
    logic [LVL_W-1:0] level_q;
    acc_t             acc;

    always_comb begin
        readable = (level_q != '0);
        writable = (level_q != LVL_W'(DEPTH));
        acc.push = wr_en && writable && !replace;
        acc.over = wr_en && replace && readable;
        acc.pop  = rd_en && readable;
        if (acc.push)
            kind = WK_APPEND;
        else if (acc.over)
            kind = WK_OVERWRITE;
        else
            kind = WK_IDLE;
        wr_addr = acc.over ? PTR_W'(step_back(int'(wr_ptr_q), DEPTH)) : wr_ptr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            level_q  <= '0;
        end else begin
            if (acc.push)
                wr_ptr_q <= PTR_W'(step_fwd(int'(wr_ptr_q), DEPTH));
            if (acc.pop)
                rd_ptr_q <= PTR_W'(step_fwd(int'(rd_ptr_q), DEPTH));
            case ({acc.push, acc.pop})
                2'b10:   level_q <= level_q + LVL_W'(1);
                2'b01:   level_q <= level_q - LVL_W'(1);
                default: level_q <= level_q;
            endcase
        end
    end

    assign rd_addr = rd_ptr_q;
    assign pop     = acc.pop;
    assign level   = level_q;

endmodule

// File: rtl/fifo_rp_store.sv
module fifo_rp_store
    import fifo_rp_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DEPTH = 5,
    parameter bit FWFT  = 1'b1,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_kind_e         kind,
    input  logic [PTR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0] din,
    input  logic [PTR_W-1:0] rd_addr,
    input  logic             pop,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] slot_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                slot_q[i] <= '0;
        end else if (kind != WK_IDLE) begin
            slot_q[wr_addr] <= din;
        end
    end

    generate
        if (FWFT) begin : g_fall_through
            logic unused_pop;
            assign unused_pop = pop;
            assign dout = slot_q[rd_addr];
        end else begin : g_registered
            logic [WIDTH-1:0] dout_q;
            always_ff @(posedge clk) begin
                if (rst)
                    dout_q <= '0;
                else if (pop)
                    dout_q <= slot_q[rd_addr];
            end
            assign dout = dout_q;
        end
    endgenerate

endmodule

// File: rtl/fifo_rp.sv
module fifo_rp
    import fifo_rp_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DEPTH = 5,
    parameter bit FWFT  = 1'b1,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             replace,
    input  logic [WIDTH-1:0] din,
    output logic             writable,
    input  logic             rd_en,
    output logic [WIDTH-1:0] dout,
    output logic             readable,
    output logic [LVL_W-1:0] level
);

    wr_kind_e         kind;
    logic [PTR_W-1:0] wr_addr;
    logic [PTR_W-1:0] rd_addr;
    logic             pop;

    fifo_rp_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .replace  (replace),
        .rd_en    (rd_en),
        .kind     (kind),
        .wr_addr  (wr_addr),
        .rd_addr  (rd_addr),
        .pop      (pop),
        .level    (level),
        .readable (readable),
        .writable (writable)
    );

    fifo_rp_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .FWFT(FWFT)) u_store (
        .clk     (clk),
        .rst     (rst),
        .kind    (kind),
        .wr_addr (wr_addr),
        .din     (din),
        .rd_addr (rd_addr),
        .pop     (pop),
        .dout    (dout)
    );

endmodule

// File: rtl/fifo_rp_chk.sv
module fifo_rp_chk #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 5,
    parameter bit FWFT  = 1'b1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             replace,
    input logic [WIDTH-1:0] din,
    input logic             writable,
    input logic             rd_en,
    input logic [WIDTH-1:0] dout,
    input logic             readable,
    input logic [LVL_W-1:0] level
);

    p_reset_state_r1: assert property (@(posedge clk)
        $fell(rst) |-> (level == '0 && !readable && writable));

    p_level_step_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (int'(level) == int'($past(level))
                   + int'($past(wr_en && writable && !replace))
                   - int'($past(rd_en && readable))));

    p_flags_r3: assert property (@(posedge clk) disable iff (rst)
        (readable == (level != '0)) && (writable == (int'(level) < DEPTH)));

    p_empty_read_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !readable && !wr_en) |=> (level == '0 && !readable));

    p_full_drop_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !replace && !writable && !rd_en) |=> (int'(level) == DEPTH));

    generate
        if (FWFT) begin : g_fwft_checks
            p_hold_r4: assert property (@(posedge clk) disable iff (rst)
                !rd_en |=> ((dout == $past(dout)) ||
                            (level == LVL_W'(1) && $past(wr_en && (writable || replace)))));

            p_fall_through_r5: assert property (@(posedge clk) disable iff (rst)
                (!rd_en && wr_en && (writable || replace)) |=>
                    (level != LVL_W'(1) || dout == $past(din)));
        end else begin : g_reg_checks
            p_hold_r4: assert property (@(posedge clk) disable iff (rst)
                !rd_en |=> (dout == $past(dout)));
        end
    endgenerate

endmodule

bind fifo_rp fifo_rp_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH), .FWFT(FWFT)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .replace  (replace),
    .din      (din),
    .writable (writable),
    .rd_en    (rd_en),
    .dout     (dout),
    .readable (readable),
    .level    (level)
);

// File: tb/tb_fifo_rp.sv
module tb_fifo_rp;

    localparam int WIDTH = 8;
    localparam int DEPTH = 5;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic             replace = 1'b0;
    logic [WIDTH-1:0] din = '0;
    logic             rd_en = 1'b0;

    logic             f_wr, f_rd, r_wr, r_rd;
    logic [WIDTH-1:0] f_dout, r_dout;
    logic [LVL_W-1:0] f_lvl, r_lvl;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    logic [WIDTH-1:0] q[$];
    logic [WIDTH-1:0] exp_reg = '0;
    logic [15:0]      lfsr = 16'hACE1;
    logic [WIDTH-1:0] seq = 8'h10;

    always #2ns clk = ~clk;

    fifo_rp #(.WIDTH(WIDTH), .DEPTH(DEPTH), .FWFT(1'b1)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .replace(replace), .din(din),
        .writable(f_wr), .rd_en(rd_en), .dout(f_dout), .readable(f_rd), .level(f_lvl)
    );

    fifo_rp #(.WIDTH(WIDTH), .DEPTH(DEPTH), .FWFT(1'b0)) dut_reg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .replace(replace), .din(din),
        .writable(r_wr), .rd_en(rd_en), .dout(r_dout), .readable(r_rd), .level(r_lvl)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        int n = q.size();
        check(tag, "fwft level (R2)", int'(f_lvl), n);
        check(tag, "reg level (R2)", int'(r_lvl), n);
        check(tag, "fwft readable (R3)", int'(f_rd), int'(n != 0));
        check(tag, "reg readable (R3)", int'(r_rd), int'(n != 0));
        check(tag, "fwft writable (R3)", int'(f_wr), int'(n != DEPTH));
        check(tag, "reg writable (R3)", int'(r_wr), int'(n != DEPTH));
        check(tag, "reg dout (R6)", int'(r_dout), int'(exp_reg));
        if (n != 0)
            check(tag, "fwft dout head (R6)", int'(f_dout), int'(q[0]));
    endtask

    // Drive one cycle at a negedge, model the edge, compare at the next negedge.
    task automatic step(input bit w, input bit rp, input logic [WIDTH-1:0] d,
                        input bit r, input string tag);
        int n;
        bit rdbl, wrbl;
        logic [WIDTH-1:0] popped;
        wr_en = w; replace = rp; din = d; rd_en = r;
        @(posedge clk);
        n = q.size();
        rdbl = (n != 0);
        wrbl = (n != DEPTH);
        popped = '0;
        if (r && rdbl) popped = q[0];
        if (w && rp && rdbl) q[n-1] = d;
        if (r && rdbl) begin
            void'(q.pop_front());
            exp_reg = popped;
        end
        if (w && !rp && wrbl) q.push_back(d);
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic push(input string tag);
        seq = seq + 8'h01;
        step(1'b1, 1'b0, seq, 1'b0, tag);
    endtask

    initial begin
        #800000ns;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state, before any post-reset edge
        check("R1", "fwft level", int'(f_lvl), 0);
        check("R1", "fwft readable", int'(f_rd), 0);
        check("R1", "fwft writable", int'(f_wr), 1);
        check("R1", "reg dout", int'(r_dout), 0);
        check("R1", "reg level", int'(r_lvl), 0);

        // R9: reads on empty are ignored
        step(1'b0, 1'b0, 8'h00, 1'b1, "R9 empty read");
        step(1'b0, 1'b0, 8'h00, 1'b1, "R9 empty read");

        // Fill to full
        for (int i = 0; i < DEPTH; i++) push("R6 fill");

        // R8: write while full dropped, concurrent read still proceeds
        step(1'b1, 1'b0, 8'hEE, 1'b0, "R8 full write");
        step(1'b1, 1'b0, 8'hEF, 1'b1, "R8 full write+read");

        // R7: overwrite while full, then drain
        push("R6 refill");
        step(1'b1, 1'b1, 8'hA7, 1'b0, "R7 replace on full");
        for (int i = 0; i < DEPTH + 1; i++) step(1'b0, 1'b0, 8'h00, 1'b1, "R6 drain");

        // R7: overwrite on empty has no effect
        step(1'b1, 1'b1, 8'h5A, 1'b0, "R7 replace on empty");
        step(1'b0, 1'b0, 8'h00, 1'b1, "R7 replace on empty read");

        // R5: fall-through on write into empty, then overwrite single entry
        step(1'b1, 1'b0, 8'h31, 1'b0, "R5 write into empty");
        check("R5", "fwft dout after write", int'(f_dout), 32'h31);
        step(1'b1, 1'b1, 8'h32, 1'b0, "R5 replace single");
        check("R5", "fwft dout after replace", int'(f_dout), 32'h32);
        // R4: hold with idle read
        step(1'b0, 1'b0, 8'h99, 1'b0, "R4 idle hold");
        check("R4", "reg dout hold", int'(r_dout), int'(exp_reg));

        // R11: read and overwrite on the single entry in one cycle
        step(1'b1, 1'b1, 8'h44, 1'b1, "R11 read+replace");
        check("R11", "reg dout old value", int'(r_dout), 32'h32);

        // R10: wrap many times at depth 5
        for (int i = 0; i < 3 * DEPTH + 2; i++) begin
            seq = seq + 8'h01;
            step(1'b1, 1'b0, seq, (i > 1), "R10 wrap");
        end
        for (int i = 0; i < DEPTH; i++) step(1'b0, 1'b0, 8'h00, 1'b1, "R10 wrap drain");

        // R2 / R4: pseudo-random mix
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | lfsr[3], lfsr[5] & lfsr[6], lfsr[15:8],
                 lfsr[1] | (lfsr[7] & lfsr[2]), "R2 R4 random mix");
        end

        step(1'b0, 1'b0, 8'h00, 1'b0, "R4 final idle");
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule